// File: doc/BRIEF.md
# Read Data Parity Checker

This block watches the read data path of a 32-bit bus that carries one parity bit for each byte lane. When a read transfer completes, it works out which lanes hold valid data and checks even parity on each of those lanes. Two inputs decide which lanes are valid. The first is the active-low byte enables. The second is a bus width code: a narrow device drives data only on the low lanes. If any lane that is checked fails, the active-low error flag goes low for the single clock after the data is accepted.

The flag is advisory only. The read completes the same way whether parity is good or bad, and nothing else in the block responds to an error. At every other time the flag sits high. It is a plain registered output, so it always has a defined level. Systems that do not use parity can leave the flag unconnected.

Top module: `rd_parity_chk`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it is released, `perr_n` is high.
- R2: Lane i is data bits [8i+7:8i] together with parity bit `par[i]`. A lane passes when those nine bits contain an even number of ones. It fails when the count is odd.
- R3: A `bus_sz` of 2'b00 selects the 32-bit width. In that case all four lanes are candidates for checking.
- R4: A `bus_sz` of 2'b01 selects the 16-bit width. Only lanes 0 and 1 are candidates, and errors on lanes 2 and 3 are ignored.
- R5: A `bus_sz` of 2'b10 selects the 8-bit width. Only lane 0 is a candidate.
- R6: A `bus_sz` of 2'b11 is treated as the 32-bit width.
- R7: A candidate lane is checked only when its bit in `be_n` is 0. A lane whose `be_n` bit is 1 never causes an error.
- R8: When `ack` is high and `wr` is low on a rising edge, and at least one checked lane fails, `perr_n` is low for the following clock. It is high in the clock after that, unless that clock also completes a read that fails.
- R9: An `ack` with `wr` high, which marks a write, never drives `perr_n` low, whatever the data and parity are.
- R10: When `ack` is low, `perr_n` is high in the next clock, whatever the data and parity are.
- R11: `perr_n` never takes an unknown value once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_data | input | 32 | Read data bus |
| par | input | 4 | Even parity bit for each byte lane |
| be_n | input | 4 | Byte enables, active low |
| bus_sz | input | 2 | Bus width code: 00 for 32-bit, 01 for 16-bit, 10 for 8-bit, 11 for 32-bit |
| ack | input | 1 | Marks that the data on the bus is accepted this clock |
| wr | input | 1 | High when the current cycle is a write |
| perr_n | output | 1 | Parity error flag, active low, registered |

## Verification
The flag is computed fresh in every clock from the current inputs, so the only state in the block is the flag register itself. A fault in the lane mask shows up on the first read in which a disabled lane, or a lane above the bus width, carries bad parity. That read produces a false low pulse exactly one clock later. A fault in the parity reduction or in the read and write decode shows up just as quickly, as a missing pulse or a spurious one. A flag that stays low for more than one clock shows up on the next clock that accepts no data.

// File: rtl/rd_parity_chk.sv
module rd_parity_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*LANE_W-1:0]   rd_data,
  input  logic [LANES-1:0]          par,
  input  logic [LANES-1:0]          be_n,
  input  logic [1:0]                bus_sz,
  input  logic                      ack,
  input  logic                      wr,
  output logic                      perr_n
);

  localparam int HALF = (LANES > 1) ? LANES / 2 : 1;

  logic [LANES-1:0] lane_bad;
  logic [LANES-1:0] width_mask;
  logic [LANES-1:0] checked;
  logic             rd_done;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bad[i] = ^{rd_data[i*LANE_W +: LANE_W], par[i]};
    always_comb begin
      unique case (bus_sz)
        2'b01:   width_mask[i] = (i < HALF);
        2'b10:   width_mask[i] = (i == 0);
        default: width_mask[i] = 1'b1;
      endcase
    end
  end

  assign checked = width_mask & ~be_n;
  assign rd_done = ack & ~wr;

  always_ff @(posedge clk) begin
    if (!rst_n) perr_n <= 1'b1;
    else        perr_n <= ~(rd_done & |(lane_bad & checked));
  end

endmodule

module rd_parity_chk_props (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic [3:0]  par,
  input logic [3:0]  be_n,
  input logic [1:0]  bus_sz,
  input logic        ack,
  input logic        wr,
  input logic        perr_n
);
  logic [3:0] odd;
  for (genvar i = 0; i < 4; i++) begin : g_odd
    assign odd[i] = ^{rd_data[i*8 +: 8], par[i]};
  end

  AST_RESET_HIGH:   assert property (@(posedge clk) !rst_n |=> perr_n); // R1
  AST_IDLE_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) !ack |=> perr_n); // R10
  AST_WRITE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (ack && wr) |=> perr_n); // R9
  AST_BE_MASKED:    assert property (@(posedge clk) disable iff (!rst_n) (&be_n) |=> perr_n); // R7
  AST_NARROW8:      assert property (@(posedge clk) disable iff (!rst_n)
                      (bus_sz == 2'b10 && !odd[0]) |=> perr_n); // R5
  AST_NARROW16:     assert property (@(posedge clk) disable iff (!rst_n)
                      (bus_sz == 2'b01 && !odd[0] && !odd[1]) |=> perr_n); // R4
  AST_ALL_GOOD:     assert property (@(posedge clk) disable iff (!rst_n) (odd == 4'b0) |=> perr_n); // R2
  AST_FULL_CATCH:   assert property (@(posedge clk) disable iff (!rst_n)
                      (ack && !wr && bus_sz == 2'b00 && (odd & ~be_n) != 4'b0) |=> !perr_n); // R8
  AST_KNOWN:        assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(perr_n)); // R11
endmodule

bind rd_parity_chk rd_parity_chk_props u_props (.*);

// File: tb/rd_parity_chk_test.sv
module rd_parity_chk_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_data = '0;
  logic [3:0]  par = '0;
  logic [3:0]  be_n = 4'hF;
  logic [1:0]  bus_sz = 2'b00;
  logic        ack = 1'b0;
  logic        wr = 1'b0;
  logic        perr_n;

  int compared = 0;
  int mismatched = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_parity_chk uut (.*);

  function automatic logic [3:0] good_par(input logic [31:0] d);
    for (int i = 0; i < 4; i++) good_par[i] = ^d[i*8 +: 8];
  endfunction

  function automatic bit model(input logic [31:0] d, input logic [3:0] p, input logic [3:0] b,
                               input logic [1:0] s, input logic a, input logic w);
    logic [3:0] m;
    logic [3:0] bad;
    m = (s == 2'b01) ? 4'b0011 : (s == 2'b10) ? 4'b0001 : 4'b1111;
    for (int i = 0; i < 4; i++) bad[i] = ^{d[i*8 +: 8], p[i]};
    return !(a && !w && |(bad & m & ~b));
  endfunction

  task automatic drive(input logic [31:0] d, input logic [3:0] flip, input logic [3:0] b,
                       input logic [1:0] s, input logic a, input logic w, input string tag);
    @(negedge clk);
    rd_data = d; par = good_par(d) ^ flip; be_n = b; bus_sz = s; ack = a; wr = w;
    exp_q.push_back(model(d, good_par(d) ^ flip, b, s, a, w));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (perr_n !== e) begin
        mismatched++;
        $display("FAIL %s: perr_n=%b expected %b", t, perr_n, e);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (perr_n !== 1'b1) begin
      mismatched++;
      $display("FAIL R1: perr_n=%b expected 1 in reset", perr_n);
    end
    rst_n = 1'b1;
    drive(32'h0, 4'h0, 4'hF, 2'b00, 1'b0, 1'b0, "R1 after reset");
    drive(32'h12345678, 4'h0, 4'h0, 2'b00, 1'b1, 1'b0, "R2 clean read");
    drive(32'hA5A5A5A5, 4'h4, 4'h0, 2'b00, 1'b1, 1'b0, "R3 lane2 bad 32b");
    drive(32'h0, 4'h0, 4'hF, 2'b00, 1'b0, 1'b0, "R8 single pulse");
    drive(32'hFFFF0001, 4'h8, 4'h0, 2'b00, 1'b1, 1'b0, "R3 lane3 bad 32b");
    drive(32'h00FF00FF, 4'h1, 4'h0, 2'b00, 1'b1, 1'b0, "R8 back-to-back err");
    drive(32'hDEADBEEF, 4'hC, 4'h0, 2'b01, 1'b1, 1'b0, "R4 upper bad 16b");
    drive(32'hDEADBEEF, 4'h2, 4'h0, 2'b01, 1'b1, 1'b0, "R4 lane1 bad 16b");
    drive(32'hCAFEF00D, 4'hE, 4'h0, 2'b10, 1'b1, 1'b0, "R5 upper bad 8b");
    drive(32'hCAFEF00D, 4'h1, 4'h0, 2'b10, 1'b1, 1'b0, "R5 lane0 bad 8b");
    drive(32'h01020304, 4'h8, 4'h0, 2'b11, 1'b1, 1'b0, "R6 size 11 lane3");
    drive(32'h01020304, 4'hF, 4'hF, 2'b00, 1'b1, 1'b0, "R7 all disabled");
    drive(32'h01020304, 4'h2, 4'b0010, 2'b00, 1'b1, 1'b0, "R7 lane1 disabled");
    drive(32'h01020304, 4'h3, 4'b0010, 2'b00, 1'b1, 1'b0, "R7 lane0 enabled bad");
    drive(32'h77777777, 4'hF, 4'h0, 2'b00, 1'b1, 1'b1, "R9 write bad");
    drive(32'h77777777, 4'hF, 4'h0, 2'b00, 1'b0, 1'b0, "R10 no ack bad");
    for (int k = 0; k < 40; k++) begin
      logic [31:0] d;
      d = 32'h9E3779B9 * (k + 1);
      drive(d, 4'(k * 7), 4'(k * 3), 2'(k), 1'(k % 5 != 0), 1'(k % 7 == 3), "R8 sweep");
    end
    drive(32'h0, 4'h0, 4'hF, 2'b00, 1'b0, 1'b0, "R11 final idle");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule